// File: doc/BRIEF.md
# Slot-Masked TDM Serial Transmitter

This block sends words onto a shared time-division-multiplexed data line. A frame is a run of fixed-length time slots that starts when the frame sync input rises. A per-slot ownership mask chooses the slots in which this device drives the line. In every other slot the output enable stays low, so other devices on the line can drive it. The bit clock is the block's clock. During an owned slot one bit leaves per rising edge, most significant bit first.

Software supplies one action per owned slot through a small register port. Writing the data register queues a word to be sent. Writing the idle register gives up the next owned slot, and the line stays released. An empty flag requests the next action at the start of every owned slot and can raise an interrupt. If software supplies no action in time, the block sends the last data word again and records a sticky underrun, which software clears by writing a one to it.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset the output enable and interrupt are low, the ownership mask and data register read as zero, the empty flag (status bit 0) reads 1 and the underrun flag (status bit 1) reads 0.
- R2: A slot boundary happens on the clock edge where fsync is sampled high after being sampled low, and that boundary enters slot 0. Each slot lasts WORD_LEN clocks. After slot N_SLOTS-1 the line stays released until the next rise. A rise in the middle of a frame restarts it at slot 0.
- R3: In a slot whose mask bit is 0 (register address 2, bit s for slot s), the output enable stays low for the whole slot and neither status flag changes.
- R4: In an owned slot that follows a data register write (address 0), the output enable is high for the whole slot. The word is driven MSB first, one bit per clock, and the MSB appears in the cycle after the boundary edge.
- R5: In an owned slot whose latest action was a write to the idle register (address 1), the output enable stays low for the slot.
- R6: If no data or idle write happened since the previous owned boundary, the underrun flag sets and the current data register contents are sent again with the output enable high.
- R7: The empty flag sets at every owned boundary and clears on a data or idle write. The interrupt equals empty AND the interrupt enable (address 4, bit 0).
- R8: The underrun flag stays set until a status write (address 3) with bit 1 set. If a new underrun happens in the same cycle, the set wins. A set underrun does not stop later slots from sending.
- R9: A write in the same cycle as an owned boundary applies to the next owned slot. The boundary uses the state from before the write.
- R10: A read returns the data register at address 0, the mask at 2, the status at 3 and the interrupt enable at 4. Every other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Word-length frame sync; its rise starts a frame |
| txd | output | 1 | Serial data, valid while txd_oe is high |
| txd_oe | output | 1 | Output enable for the shared data line |
| irq | output | 1 | Request for the next slot action |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr |

## Verification
The assertions assume fsync and the register inputs are synchronous to the bit clock. They also assume software acts only through whole-cycle write strobes and never relies on reading the idle register. The stimulus changes every input on the falling edge only. It keeps each fsync pulse one word long. It places data writes, idle writes, missed slots, flag clears and boundary-coincident writes at fixed offsets inside each frame, and it includes one shortened frame that forces a mid-frame restart.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
   localparam logic [2:0] ADDR_DATA = 3'd0;
   localparam logic [2:0] ADDR_IDLE = 3'd1;
   localparam logic [2:0] ADDR_MASK = 3'd2;
   localparam logic [2:0] ADDR_STAT = 3'd3;
   localparam logic [2:0] ADDR_IEN  = 3'd4;
   localparam int STAT_EMPTY_BIT = 0;
   localparam int STAT_UNDER_BIT = 1;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
   parameter int WORD_LEN = 8,
   parameter int N_SLOTS  = 5,
   localparam int BIT_W   = $clog2(WORD_LEN),
   localparam int SLOT_W  = $clog2(N_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   output logic              bnd,
   output logic [SLOT_W-1:0] bnd_slot
);
   logic              fs_q;
   logic              in_frame;
   logic [BIT_W-1:0]  bit_cnt;
   logic [SLOT_W-1:0] slot_cnt;
   logic              fs_rise;
   logic              word_end;
   logic              next_valid;

   always_comb begin
      fs_rise    = fsync & ~fs_q;
      word_end   = in_frame && (bit_cnt == BIT_W'(WORD_LEN - 1));
      bnd        = fs_rise | word_end;
      bnd_slot   = fs_rise ? '0 : slot_cnt + 1'b1;
      next_valid = (bnd_slot < SLOT_W'(N_SLOTS));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q     <= 1'b0;
         in_frame <= 1'b0;
         bit_cnt  <= '0;
         slot_cnt <= '0;
      end else begin
         fs_q <= fsync;
         if (bnd) begin
            bit_cnt  <= '0;
            slot_cnt <= bnd_slot;
            in_frame <= next_valid;
         end else if (in_frame) begin
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

   // R2: a sync rise always restarts at slot 0, bit 0
   assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !fs_q) |=> (in_frame && slot_cnt == '0 && bit_cnt == '0));
   // R2: counting stops after the last slot until a new rise
   assert_frame_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame && !(fsync && !fs_q)) |=> !in_frame);
endmodule

// File: rtl/tdm_tx_regs.sv
module tdm_tx_regs
   import tdm_tx_pkg::*;
#(
   parameter int WORD_LEN = 8,
   parameter int N_SLOTS  = 5,
   parameter int REG_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [2:0]          addr,
   input  logic [REG_W-1:0]    wdata,
   input  logic                own,
   output logic [WORD_LEN-1:0] data_q,
   output logic [N_SLOTS-1:0]  mask_q,
   output logic                empty_q,
   output logic                idle_q,
   output logic                under_q,
   output logic                irq,
   output logic [REG_W-1:0]    rdata
);
   logic ien_q;
   logic wr_data, wr_idle, wr_mask, wr_stat, wr_ien;
   logic unused_wdata;

   always_comb begin
      wr_data = we && (addr == ADDR_DATA);
      wr_idle = we && (addr == ADDR_IDLE);
      wr_mask = we && (addr == ADDR_MASK);
      wr_stat = we && (addr == ADDR_STAT);
      wr_ien  = we && (addr == ADDR_IEN);
      unused_wdata = ^wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         mask_q  <= '0;
         empty_q <= 1'b1;
         idle_q  <= 1'b0;
         under_q <= 1'b0;
         ien_q   <= 1'b0;
      end else begin
         if (wr_data) data_q <= wdata[WORD_LEN-1:0];
         if (wr_mask) mask_q <= wdata[N_SLOTS-1:0];
         if (wr_ien)  ien_q  <= wdata[0];
         if (wr_data)      idle_q <= 1'b0;
         else if (wr_idle) idle_q <= 1'b1;
         if (wr_data || wr_idle) empty_q <= 1'b0;
         else if (own)           empty_q <= 1'b1;
         if (own && empty_q)                           under_q <= 1'b1;
         else if (wr_stat && wdata[STAT_UNDER_BIT])    under_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADDR_DATA: rdata = REG_W'(data_q);
         ADDR_MASK: rdata = REG_W'(mask_q);
         ADDR_STAT: begin
            rdata[STAT_EMPTY_BIT] = empty_q;
            rdata[STAT_UNDER_BIT] = under_q;
         end
         ADDR_IEN:  rdata = REG_W'(ien_q);
         default:   rdata = '0;
      endcase
   end

   assign irq = empty_q & ien_q;

   // R6: a missed owned slot always leaves the underrun flag set
   assert_underrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (own && empty_q) |=> under_q);
   // R7: an owned boundary with no write raises the request
   assert_empty_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (own && !wr_data && !wr_idle) |=> empty_q);
   // R7: any data or idle write answers the request
   assert_write_answers_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data || wr_idle) |=> !empty_q);
   // R8: clear by write-one unless a new underrun lands in the same cycle
   assert_underrun_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && wdata[STAT_UNDER_BIT] && !(own && empty_q)) |=> !under_q);
   // R8: sticky while not cleared
   assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (under_q && !wr_stat) |=> under_q);
endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
   parameter int WORD_LEN = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bnd,
   input  logic                own,
   input  logic                empty,
   input  logic                idle,
   input  logic [WORD_LEN-1:0] data,
   output logic                txd,
   output logic                oe
);
   logic [WORD_LEN-1:0] sreg;
   logic                send;

   assign send = own & (empty | ~idle);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         oe   <= 1'b0;
      end else if (bnd) begin
         oe <= send;
         if (send) sreg <= data;
      end else if (oe) begin
         sreg <= {sreg[WORD_LEN-2:0], 1'b0};
      end
   end

   assign txd = oe & sreg[WORD_LEN-1];

   // R3: a boundary into a slot not owned releases the line
   assert_unowned_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && !own) |=> !oe);
   // R5: an idle action keeps the line released
   assert_idle_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (own && !empty && idle) |=> !oe);
   // R4 and R6: a sending slot drives the word's MSB first
   assert_send_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (own && (empty || !idle)) |=> (oe && txd == $past(data[WORD_LEN-1])));
   // R2: the enable only changes on slot boundaries
   assert_oe_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(oe));
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
   import tdm_tx_pkg::*;
#(
   parameter int WORD_LEN = 8,
   parameter int N_SLOTS  = 5,
   parameter int REG_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   output logic             txd,
   output logic             txd_oe,
   output logic             irq,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata
);
   localparam int SLOT_W = $clog2(N_SLOTS + 1);

   if (WORD_LEN < 8 || WORD_LEN > 16) begin : g_bad_word
      $error("WORD_LEN must lie in 8..16");
   end
   if (N_SLOTS < 1 || N_SLOTS > REG_W) begin : g_bad_slots
      $error("N_SLOTS must lie in 1..REG_W");
   end
   if (REG_W < WORD_LEN) begin : g_bad_regw
      $error("REG_W must hold a full word");
   end

   logic                bnd;
   logic [SLOT_W-1:0]   bnd_slot;
   logic [N_SLOTS-1:0]  slot_hit;
   logic                own;
   logic [WORD_LEN-1:0] data_q;
   logic [N_SLOTS-1:0]  mask_q;
   logic                empty_q, idle_q, under_q;

   tdm_slot_timer #(.WORD_LEN(WORD_LEN), .N_SLOTS(N_SLOTS)) u_timer (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .bnd(bnd), .bnd_slot(bnd_slot)
   );

   for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      assign slot_hit[i] = mask_q[i] && (bnd_slot == SLOT_W'(i));
   end
   assign own = bnd & (|slot_hit);

   tdm_tx_regs #(.WORD_LEN(WORD_LEN), .N_SLOTS(N_SLOTS), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .own(own), .data_q(data_q), .mask_q(mask_q), .empty_q(empty_q),
      .idle_q(idle_q), .under_q(under_q), .irq(irq), .rdata(reg_rdata)
   );

   tdm_tx_shifter #(.WORD_LEN(WORD_LEN)) u_shift (
      .clk(clk), .rst_n(rst_n), .bnd(bnd), .own(own), .empty(empty_q),
      .idle(idle_q), .data(data_q), .txd(txd), .oe(txd_oe)
   );

   // R8: an underrun never blocks the following send
   assert_underrun_still_sends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (own && empty_q) |=> txd_oe);
   // R1: ownership at most one slot per boundary
   assert_one_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_hit));
endmodule

// File: tb/sim_tdm_slot_tx.sv
module sim_tdm_slot_tx;
   localparam int W  = 8;
   localparam int NS = 5;
   localparam int RW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fsync = 1'b0;
   logic          txd, txd_oe, irq;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = 3'd3;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2 clk = ~clk;

   tdm_slot_tx #(.WORD_LEN(W), .N_SLOTS(NS), .REG_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .txd(txd), .txd_oe(txd_oe),
      .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   // behavioural reference model
   int m_fsq = 0, m_bit = 0, m_slot = 0, m_in = 0;
   int m_emp = 1, m_idle = 0, m_und = 0, m_data = 0, m_sreg = 0, m_oe = 0;
   int m_mask = 0, m_ien = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fsq = 0; m_bit = 0; m_slot = 0; m_in = 0; m_emp = 1; m_idle = 0;
         m_und = 0; m_data = 0; m_sreg = 0; m_oe = 0; m_mask = 0; m_ien = 0;
      end else begin
         int nxt; bit b; bit own; bit set_und;
         b = 0; nxt = 0; set_und = 0;
         if (fsync && m_fsq == 0) begin b = 1; nxt = 0; end
         else if (m_in != 0 && m_bit == W - 1) begin b = 1; nxt = m_slot + 1; end
         own = b && nxt < NS && ((m_mask >> nxt) & 1) != 0;
         if (b) begin
            if (own) begin
               if (m_emp != 0) begin set_und = 1; m_oe = 1; m_sreg = m_data; end
               else if (m_idle != 0) m_oe = 0;
               else begin m_oe = 1; m_sreg = m_data; end
               m_emp = 1;
            end else m_oe = 0;
            m_slot = nxt; m_bit = 0; m_in = (nxt < NS) ? 1 : 0;
         end else begin
            if (m_in != 0) m_bit++;
            if (m_oe != 0) m_sreg = (m_sreg << 1) & ((1 << W) - 1);
         end
         if (reg_we) begin
            case (reg_addr)
               3'd0: begin m_data = int'(reg_wdata) & ((1 << W) - 1); m_emp = 0; m_idle = 0; end
               3'd1: begin m_emp = 0; m_idle = 1; end
               3'd2: m_mask = int'(reg_wdata) & ((1 << NS) - 1);
               3'd3: if (reg_wdata[1]) m_und = 0;
               3'd4: m_ien = int'(reg_wdata[0]);
               default: ;
            endcase
         end
         if (set_und) m_und = 1;
         m_fsq = fsync ? 1 : 0;
      end
   end

   function automatic int model_read(input logic [2:0] a);
      case (a)
         3'd0: return m_data;
         3'd2: return m_mask;
         3'd3: return (m_und << 1) | m_emp;
         3'd4: return m_ien;
         default: return 0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the rising edge
   task automatic compare_all();
      check(int'(txd_oe) == m_oe, "R2/R3/R5 txd_oe", int'(txd_oe), m_oe);
      if (m_oe != 0)
         check(int'(txd) == ((m_sreg >> (W - 1)) & 1), "R4/R6 txd bit", int'(txd),
               (m_sreg >> (W - 1)) & 1);
      check(int'(irq) == (m_emp & m_ien), "R7 irq", int'(irq), m_emp & m_ien);
      check(int'(reg_rdata) == model_read(reg_addr), "R10/R7/R8 readback",
            int'(reg_rdata), model_read(reg_addr));
   endtask

   task automatic step(input bit fs, input bit we, input logic [2:0] a, input int d);
      @(negedge clk);
      if (rst_n) compare_all();
      fsync     = fs;
      reg_we    = we;
      reg_addr  = a;
      reg_wdata = RW'(d);
   endtask

   task automatic act(input bit fs, input int kind, input int val);
      // kind 0,1: data write; 2: idle write; 3: nothing
      if (kind <= 1)      step(fs, 1'b1, 3'd0, val);
      else if (kind == 2) step(fs, 1'b1, 3'd1, 0);
      else                step(fs, 1'b0, 3'd3, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(txd_oe == 1'b0, "R1 oe after reset", int'(txd_oe), 0);
      check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
      check(reg_rdata == RW'(1), "R1 status after reset", int'(reg_rdata), 1);
      step(0, 0, 3'd2, 0);
      step(0, 0, 3'd0, 0);
      @(negedge clk);
      check(reg_rdata == '0 && reg_addr == 3'd0, "R1 data after reset", int'(reg_rdata), 0);
      step(0, 1, 3'd2, 5'b01001);
      step(0, 1, 3'd0, 8'hA5);
      step(0, 0, 3'd7, 0);
      step(0, 0, 3'd3, 0);
      for (int f = 0; f < 14; f++) begin
         int len = (f == 10) ? 20 : 48;
         bit edge_wr = (f % 5 == 4);   // R9: writes on boundary cycles
         int o0 = edge_wr ? 0 : 5;
         int o1 = edge_wr ? 24 : 28;
         if (f == 2) step(0, 1, 3'd4, 1);
         if (f == 8) step(0, 1, 3'd2, 5'b10110);
         if (f == 12) step(0, 1, 3'd2, 5'b11111);
         for (int c = 0; c < len; c++) begin
            bit fs = (c < W);
            if (c == o0)      act(fs, (f * 3) % 4, 8'h3C + f * 17);
            else if (c == o1) act(fs, (f * 3 + 1) % 4, 8'h81 + f * 29);
            else if (c == 40 && f % 3 == 2) step(fs, 1'b1, 3'd3, 2);   // R8 clear
            else if (c == 24 && f % 4 == 1) step(fs, 1'b1, 3'd3, 2);   // R8 set vs clear
            else if (c == 44) step(fs, 1'b0, 3'd4, 0);
            else step(fs, 1'b0, 3'd3, 0);
         end
      end
      repeat (10) step(0, 0, 3'd3, 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule